// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a packet DMA engine. Software builds a chain of four-word buffer descriptors in the channel's local descriptor memory, marks each one as owned by hardware, and starts the channel by writing the word address of the first descriptor into the head register. The channel walks the chain one descriptor at a time. For each packet it presents the payload start address (buffer pointer plus offset), the packet length and the buffer length on a valid/ready handshake toward the payload mover.

When a packet has been taken, the channel writes the descriptor's control word back. It clears the hardware-ownership bit and, if the next pointer is null, sets an end-of-queue bit and goes idle until the head register is written again. Each retired descriptor raises a pending interrupt. The interrupt clears only when software writes that descriptor's address to the completion register. An end-of-interrupt code briefly drops the line so that an edge-sensitive controller sees a fresh edge for work that is still pending. A level enable gates descriptor fetches, and a descriptor found without the ownership bit stops the channel with a host-error flag.

Top module: `txdma_chan`

## Requirements
- R1: A non-zero head write while the channel is idle fetches the descriptor at that word address. Its words are: +0 next pointer (zero = null), +1 buffer pointer, +2 {offset[31:16], buffer length[15:0]}, +3 {control[31:16], packet length[15:0]}. The channel then presents pkt_addr = buffer pointer + offset, pkt_len and pkt_buf_len with pkt_valid high.
- R2: While pkt_valid is high and pkt_ready is low, pkt_valid, pkt_addr, pkt_len and pkt_buf_len hold. Exactly one packet is transferred per cycle with both high.
- R3: After a packet is taken, a non-zero next pointer is followed, and descriptors are emitted in chain order.
- R4: On retiring a descriptor the channel clears bit 29 (ownership) of word +3 and leaves bits 31 and 30 (start/end of packet) and the packet length unchanged.
- R5: A retired descriptor whose next pointer is null gets bit 28 (end of queue) set in word +3, and the channel returns to idle (active low). A descriptor with a non-null next pointer keeps bit 28 clear.
- R6: A fetched descriptor with bit 29 clear sets host_err, produces no packet and leaves the channel idle. The next accepted head write clears host_err.
- R7: A head write of zero is ignored.
- R8: While tx_en is low no descriptor is fetched. A packet already presented still completes and retires when tx_en drops.
- R9: irq rises when a descriptor retires and stays high until cpl_wdata equal to the last retired descriptor's address is written with cpl_we. A write of any other value leaves irq high.
- R10: An eoi_we with eoi_code = 2 while irq is pending drives irq low for exactly one cycle, after which it returns high. Other codes have no effect on irq.
- R11: After reset, pkt_valid, irq, host_err and active are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Level enable for descriptor fetches |
| mem_we | input | 1 | Descriptor memory write strobe |
| mem_waddr | input | 6 | Descriptor memory write word address |
| mem_wdata | input | 32 | Descriptor memory write data |
| mem_raddr | input | 6 | Descriptor memory read word address |
| mem_rdata | output | 32 | Descriptor memory read data (combinational) |
| head_we | input | 1 | Head register write strobe |
| head_wdata | input | 6 | Word address of the first descriptor |
| cpl_we | input | 1 | Completion register write strobe |
| cpl_wdata | input | 6 | Address of the acknowledged descriptor |
| eoi_we | input | 1 | End-of-interrupt write strobe |
| eoi_code | input | 2 | End-of-interrupt code (2 = transmit) |
| pkt_valid | output | 1 | Packet request valid |
| pkt_ready | input | 1 | Packet request accepted |
| pkt_addr | output | 32 | Payload start address |
| pkt_len | output | 16 | Packet length |
| pkt_buf_len | output | 16 | Buffer length |
| irq | output | 1 | Transmit completion interrupt |
| host_err | output | 1 | Descriptor fetched without ownership |
| active | output | 1 | Channel is walking a chain |

## Verification
The bench targets a chain ending on its first descriptor, random backpressure on long chains, and a disable that lands while a packet is being presented. Each of these can be mishandled: a design that loses the next pointer would stop early or skip descriptors, and one that ignores the enable mid-packet would fetch the following descriptor. Write-back faults show up in descriptor read-back, where end-of-queue lands on the wrong descriptor or ownership is left set. The bench also sends wrong-address acknowledges and non-transmit end-of-interrupt codes. An interrupt that clears on any write, or a blank that never ends, is caught at the irq pin.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 16;

    // control-word bit positions (upper half of descriptor word +3)
    localparam int BIT_SOP = 31;
    localparam int BIT_EOP = 30;
    localparam int BIT_OWN = 29;
    localparam int BIT_EOQ = 28;

    // word offsets inside a descriptor
    localparam int OFS_NEXT = 0;
    localparam int OFS_BUF  = 1;
    localparam int OFS_SIZE = 2;
    localparam int OFS_CTRL = 3;
    localparam int DESC_WORDS = 4;

    typedef enum logic [1:0] {
        WS_IDLE,
        WS_FETCH,
        WS_SEND,
        WS_RETIRE
    } walk_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] next;
        logic [WORD_W-1:0] buf_ptr;
        logic [LEN_W-1:0]  buf_off;
        logic [LEN_W-1:0]  buf_len;
        logic [WORD_W-1:0] ctrl;
    } desc_t;

    function automatic desc_t unpack_desc(input logic [DESC_WORDS-1:0][WORD_W-1:0] w);
        desc_t d;
        d.next    = w[OFS_NEXT];
        d.buf_ptr = w[OFS_BUF];
        d.buf_off = w[OFS_SIZE][WORD_W-1:LEN_W];
        d.buf_len = w[OFS_SIZE][LEN_W-1:0];
        d.ctrl    = w[OFS_CTRL];
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] retire_word(input logic [WORD_W-1:0] ctrl,
                                                      input logic last);
        logic [WORD_W-1:0] r;
        r          = ctrl;
        r[BIT_OWN] = 1'b0;
        if (last) r[BIT_EOQ] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/txdma_desc_ram.sv
module txdma_desc_ram
    import txdma_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                               clk,
    input  logic                               sw_we,
    input  logic [AW-1:0]                      sw_waddr,
    input  logic [WORD_W-1:0]                  sw_wdata,
    input  logic [AW-1:0]                      sw_raddr,
    output logic [WORD_W-1:0]                  sw_rdata,
    input  logic                               eng_we,
    input  logic [AW-1:0]                      eng_waddr,
    input  logic [WORD_W-1:0]                  eng_wdata,
    input  logic [AW-1:0]                      eng_base,
    output logic [DESC_WORDS-1:0][WORD_W-1:0]  eng_words
);

    logic [WORD_W-1:0] mem [DEPTH];

    // software write is applied last, so it wins on a same-word collision
    always_ff @(posedge clk) begin
        if (eng_we) mem[eng_waddr] <= eng_wdata;
        if (sw_we)  mem[sw_waddr]  <= sw_wdata;
    end

    assign sw_rdata = mem[sw_raddr];

    for (genvar g = 0; g < DESC_WORDS; g++) begin : g_rd
        assign eng_words[g] = mem[eng_base + AW'(g)];
    end

endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
    import txdma_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              tx_en,
    input  logic                              head_we,
    input  logic [AW-1:0]                     head_wdata,
    output logic [AW-1:0]                     fetch_base,
    input  logic [DESC_WORDS-1:0][WORD_W-1:0] fetch_words,
    output logic                              wb_we,
    output logic [AW-1:0]                     wb_addr,
    output logic [WORD_W-1:0]                 wb_data,
    output logic                              done_pulse,
    output logic [AW-1:0]                     done_addr,
    output logic                              pkt_valid,
    input  logic                              pkt_ready,
    output logic [WORD_W-1:0]                 pkt_addr,
    output logic [LEN_W-1:0]                  pkt_len,
    output logic [LEN_W-1:0]                  pkt_buf_len,
    output logic                              host_err,
    output logic                              active
);

    walk_state_t st;
    logic [AW-1:0] cur;
    desc_t         cur_d;
    desc_t         fetched;
    logic          at_tail;

    assign fetch_base = cur;
    assign fetched    = unpack_desc(fetch_words);
    assign at_tail    = (cur_d.next == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= WS_IDLE;
            cur      <= '0;
            cur_d    <= '0;
            host_err <= 1'b0;
        end else begin
            unique case (st)
                WS_IDLE: begin
                    if (head_we && head_wdata != '0) begin
                        cur      <= head_wdata;
                        host_err <= 1'b0;
                        st       <= WS_FETCH;
                    end
                end
                WS_FETCH: begin
                    if (tx_en) begin
                        if (fetched.ctrl[BIT_OWN]) begin
                            cur_d <= fetched;
                            st    <= WS_SEND;
                        end else begin
                            host_err <= 1'b1;
                            st       <= WS_IDLE;
                        end
                    end
                end
                WS_SEND: begin
                    if (pkt_ready) st <= WS_RETIRE;
                end
                WS_RETIRE: begin
                    if (at_tail) begin
                        st <= WS_IDLE;
                    end else begin
                        cur <= cur_d.next[AW-1:0];
                        st  <= WS_FETCH;
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    assign wb_we       = (st == WS_RETIRE);
    assign wb_addr     = cur + AW'(OFS_CTRL);
    assign wb_data     = retire_word(cur_d.ctrl, at_tail);
    assign done_pulse  = (st == WS_RETIRE);
    assign done_addr   = cur;
    assign pkt_valid   = (st == WS_SEND);
    assign pkt_addr    = cur_d.buf_ptr + WORD_W'(cur_d.buf_off);
    assign pkt_len     = cur_d.ctrl[LEN_W-1:0];
    assign pkt_buf_len = cur_d.buf_len;
    assign active      = (st != WS_IDLE);

endmodule

// File: rtl/txdma_irq.sv
module txdma_irq #(
    parameter int AW       = 6,
    parameter int EOI_W    = 2,
    parameter int EOI_CODE = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             done_pulse,
    input  logic [AW-1:0]    done_addr,
    input  logic             cpl_we,
    input  logic [AW-1:0]    cpl_wdata,
    input  logic             eoi_we,
    input  logic [EOI_W-1:0] eoi_code,
    output logic [AW-1:0]    last_done,
    output logic             irq
);

    logic pending;
    logic blank;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending   <= 1'b0;
            blank     <= 1'b0;
            last_done <= '0;
        end else begin
            blank <= eoi_we && (eoi_code == EOI_W'(EOI_CODE)) && pending;
            if (done_pulse) begin
                pending   <= 1'b1;
                last_done <= done_addr;
            end else if (cpl_we && cpl_wdata == last_done) begin
                pending <= 1'b0;
            end
        end
    end

    assign irq = pending && !blank;

endmodule

// File: rtl/txdma_chan.sv
module txdma_chan
    import txdma_pkg::*;
#(
    parameter int DEPTH_WORDS = 64,
    parameter int EOI_W       = 2,
    parameter int EOI_TX_CODE = 2,
    localparam int AW         = $clog2(DEPTH_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             mem_we,
    input  logic [AW-1:0]    mem_waddr,
    input  logic [31:0]      mem_wdata,
    input  logic [AW-1:0]    mem_raddr,
    output logic [31:0]      mem_rdata,
    input  logic             head_we,
    input  logic [AW-1:0]    head_wdata,
    input  logic             cpl_we,
    input  logic [AW-1:0]    cpl_wdata,
    input  logic             eoi_we,
    input  logic [EOI_W-1:0] eoi_code,
    output logic             pkt_valid,
    input  logic             pkt_ready,
    output logic [31:0]      pkt_addr,
    output logic [15:0]      pkt_len,
    output logic [15:0]      pkt_buf_len,
    output logic             irq,
    output logic             host_err,
    output logic             active
);

    logic [AW-1:0]                     fetch_base;
    logic [DESC_WORDS-1:0][WORD_W-1:0] fetch_words;
    logic                              wb_we;
    logic [AW-1:0]                     wb_addr;
    logic [WORD_W-1:0]                 wb_data;
    logic                              done_pulse;
    logic [AW-1:0]                     done_addr;
    logic [AW-1:0]                     last_done;

    txdma_desc_ram #(.DEPTH(DEPTH_WORDS)) u_ram (
        .clk      (clk),
        .sw_we    (mem_we),
        .sw_waddr (mem_waddr),
        .sw_wdata (mem_wdata),
        .sw_raddr (mem_raddr),
        .sw_rdata (mem_rdata),
        .eng_we   (wb_we),
        .eng_waddr(wb_addr),
        .eng_wdata(wb_data),
        .eng_base (fetch_base),
        .eng_words(fetch_words)
    );

    txdma_walker #(.AW(AW)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .head_we    (head_we),
        .head_wdata (head_wdata),
        .fetch_base (fetch_base),
        .fetch_words(fetch_words),
        .wb_we      (wb_we),
        .wb_addr    (wb_addr),
        .wb_data    (wb_data),
        .done_pulse (done_pulse),
        .done_addr  (done_addr),
        .pkt_valid  (pkt_valid),
        .pkt_ready  (pkt_ready),
        .pkt_addr   (pkt_addr),
        .pkt_len    (pkt_len),
        .pkt_buf_len(pkt_buf_len),
        .host_err   (host_err),
        .active     (active)
    );

    txdma_irq #(.AW(AW), .EOI_W(EOI_W), .EOI_CODE(EOI_TX_CODE)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .done_pulse(done_pulse),
        .done_addr (done_addr),
        .cpl_we    (cpl_we),
        .cpl_wdata (cpl_wdata),
        .eoi_we    (eoi_we),
        .eoi_code  (eoi_code),
        .last_done (last_done),
        .irq       (irq)
    );

endmodule

// File: rtl/txdma_chan_sva.sv
module txdma_chan_sva #(
    parameter int AW       = 6,
    parameter int EOI_W    = 2,
    parameter int EOI_CODE = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             pkt_valid,
    input logic             pkt_ready,
    input logic [31:0]      pkt_addr,
    input logic [15:0]      pkt_len,
    input logic [15:0]      pkt_buf_len,
    input logic             irq,
    input logic             host_err,
    input logic             active,
    input logic             cpl_we,
    input logic [AW-1:0]    cpl_wdata,
    input logic             eoi_we,
    input logic [EOI_W-1:0] eoi_code,
    input logic             done_pulse,
    input logic [AW-1:0]    last_done
);

    a_r2_hold_stalled: assert property (@(posedge clk) disable iff (rst)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_addr)
                                    && $stable(pkt_len) && $stable(pkt_buf_len));

    a_r8_fetch_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_valid) |-> $past(tx_en));

    a_r6_error_is_idle: assert property (@(posedge clk) disable iff (rst)
        host_err |-> !active && !pkt_valid);

    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        cpl_we && cpl_wdata == last_done && !done_pulse |=> !irq);

    a_r9_retire_raises: assert property (@(posedge clk) disable iff (rst)
        done_pulse && !eoi_we |=> irq);

    a_r10_eoi_blank: assert property (@(posedge clk) disable iff (rst)
        eoi_we && eoi_code == EOI_W'(EOI_CODE) && irq |=> !irq);

endmodule

bind txdma_chan txdma_chan_sva #(.AW(AW), .EOI_W(EOI_W), .EOI_CODE(EOI_TX_CODE)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .tx_en      (tx_en),
    .pkt_valid  (pkt_valid),
    .pkt_ready  (pkt_ready),
    .pkt_addr   (pkt_addr),
    .pkt_len    (pkt_len),
    .pkt_buf_len(pkt_buf_len),
    .irq        (irq),
    .host_err   (host_err),
    .active     (active),
    .cpl_we     (cpl_we),
    .cpl_wdata  (cpl_wdata),
    .eoi_we     (eoi_we),
    .eoi_code   (eoi_code),
    .done_pulse (done_pulse),
    .last_done  (last_done)
);

// File: tb/test_txdma_chan.sv
module test_txdma_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic        mem_we = 1'b0;
    logic [5:0]  mem_waddr = '0;
    logic [31:0] mem_wdata = '0;
    logic [5:0]  mem_raddr = '0;
    logic [31:0] mem_rdata;
    logic        head_we = 1'b0;
    logic [5:0]  head_wdata = '0;
    logic        cpl_we = 1'b0;
    logic [5:0]  cpl_wdata = '0;
    logic        eoi_we = 1'b0;
    logic [1:0]  eoi_code = '0;
    logic        pkt_valid;
    logic        pkt_ready = 1'b0;
    logic [31:0] pkt_addr;
    logic [15:0] pkt_len;
    logic [15:0] pkt_buf_len;
    logic        irq;
    logic        host_err;
    logic        active;

    txdma_chan i_txdma_chan (.*);

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench copy of each slot's descriptor (slot k lives at word 4*k)
    logic [31:0] s_next [16];
    logic [31:0] s_buf  [16];
    logic [15:0] s_off  [16];
    logic [15:0] s_blen [16];
    logic [31:0] s_ctrl [16];
    int exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr_mem(input logic [5:0] a, input logic [31:0] d);
        mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic rd_mem(input logic [5:0] a, output logic [31:0] d);
        mem_raddr = a;
        #1;
        d = mem_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input bit own, input logic [15:0] plen);
        return {1'b1, 1'b1, own, 13'b0, plen};
    endfunction

    function automatic logic [31:0] retired(input logic [31:0] c, input bit last);
        logic [31:0] r;
        r = c;
        r[29] = 1'b0;
        if (last) r[28] = 1'b1;
        return r;
    endfunction

    task automatic put_desc(input int slot, input int nxt, input bit own);
        logic [15:0] blen;
        blen = 16'(64 + ($urandom % 1455));
        s_next[slot] = (nxt == 0) ? 32'd0 : 32'(nxt * 4);
        s_buf[slot]  = $urandom;
        s_off[slot]  = 16'($urandom % 16);
        s_blen[slot] = blen;
        s_ctrl[slot] = ctrl_word(own, blen);
        wr_mem(6'(slot * 4),     s_next[slot]);
        wr_mem(6'(slot * 4 + 1), s_buf[slot]);
        wr_mem(6'(slot * 4 + 2), {s_off[slot], s_blen[slot]});
        wr_mem(6'(slot * 4 + 3), s_ctrl[slot]);
    endtask

    task automatic kick(input logic [5:0] a);
        head_we = 1'b1; head_wdata = a;
        @(negedge clk);
        head_we = 1'b0;
    endtask

    task automatic ack(input logic [5:0] a);
        cpl_we = 1'b1; cpl_wdata = a;
        @(negedge clk);
        cpl_we = 1'b0;
    endtask

    // drive random ready, compare every accepted packet, until idle and queue empty
    task automatic drain(input int pct);
        for (int c = 0; c < 2000; c++) begin
            int slot;
            pkt_ready = (($urandom % 100) < pct);
            if (pkt_valid && pkt_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected packet", pkt_addr, 0);
                end else begin
                    slot = exp_q.pop_front();
                    chk(pkt_addr == s_buf[slot] + 32'(s_off[slot]), "R1", "pkt_addr",
                        pkt_addr, s_buf[slot] + 32'(s_off[slot]));
                    chk(pkt_len == s_ctrl[slot][15:0], "R3", "pkt_len order",
                        32'(pkt_len), 32'(s_ctrl[slot][15:0]));
                    chk(pkt_buf_len == s_blen[slot], "R1", "pkt_buf_len",
                        32'(pkt_buf_len), 32'(s_blen[slot]));
                end
            end
            @(negedge clk);
            if (!active && exp_q.size() == 0) break;
        end
        pkt_ready = 1'b0;
        chk(exp_q.size() == 0, "R3", "packets left undelivered", 32'(exp_q.size()), 0);
    endtask

    task automatic check_retired(input int slot, input bit last);
        logic [31:0] w;
        rd_mem(6'(slot * 4 + 3), w);
        chk(w[29] == 1'b0 && w[31:30] == 2'b11 && w[15:0] == s_ctrl[slot][15:0],
            "R4", "ownership handback", w, retired(s_ctrl[slot], last));
        chk(w[28] == last, "R5", "end-of-queue bit", 32'(w[28]), 32'(last));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int chain[$];
        logic [31:0] w;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(!pkt_valid, "R11", "pkt_valid after reset", 32'(pkt_valid), 0);
        chk(!irq,       "R11", "irq after reset",       32'(irq), 0);
        chk(!host_err,  "R11", "host_err after reset",  32'(host_err), 0);
        chk(!active,    "R11", "active after reset",    32'(active), 0);

        tx_en = 1'b1;

        // R7 null head write ignored
        kick(6'd0);
        repeat (3) @(negedge clk);
        chk(!active && !pkt_valid, "R7", "null head started channel", 32'(active), 0);

        // single-descriptor chain, always ready: R1 R5 R9
        put_desc(1, 0, 1'b1);
        exp_q.push_back(1);
        kick(6'd4);
        drain(100);
        check_retired(1, 1'b1);
        chk(!active, "R5", "idle after null next", 32'(active), 0);
        chk(irq, "R9", "irq after retire", 32'(irq), 1);

        // R10 wrong code no effect, right code blanks one cycle
        eoi_we = 1'b1; eoi_code = 2'd1;
        @(negedge clk);
        eoi_we = 1'b0;
        chk(irq, "R10", "irq after non-transmit eoi", 32'(irq), 1);
        @(negedge clk);
        chk(irq, "R10", "irq one cycle after non-transmit eoi", 32'(irq), 1);
        eoi_we = 1'b1; eoi_code = 2'd2;
        @(negedge clk);
        eoi_we = 1'b0;
        chk(!irq, "R10", "irq blank after eoi", 32'(irq), 0);
        @(negedge clk);
        chk(irq, "R10", "irq back after blank", 32'(irq), 1);

        // R9 wrong ack keeps irq, right ack clears
        ack(6'd8);
        chk(irq, "R9", "irq after mismatched ack", 32'(irq), 1);
        ack(6'd4);
        chk(!irq, "R9", "irq after matching ack", 32'(irq), 0);

        // R8 enable gating and in-flight completion
        put_desc(2, 3, 1'b1);
        put_desc(3, 0, 1'b1);
        tx_en = 1'b0;
        kick(6'd8);
        repeat (10) @(negedge clk);
        chk(!pkt_valid && active, "R8", "fetch while disabled", 32'(pkt_valid), 0);
        tx_en = 1'b1;
        for (int c = 0; c < 10 && !pkt_valid; c++) @(negedge clk);
        chk(pkt_valid, "R8", "fetch after enable", 32'(pkt_valid), 1);
        repeat (2) @(negedge clk);
        chk(pkt_valid && pkt_addr == s_buf[2] + 32'(s_off[2]), "R2", "held under stall",
            pkt_addr, s_buf[2] + 32'(s_off[2]));
        tx_en = 1'b0;
        pkt_ready = 1'b1;
        @(negedge clk);
        pkt_ready = 1'b0;
        repeat (10) @(negedge clk);
        chk(!pkt_valid, "R8", "next fetched while disabled", 32'(pkt_valid), 0);
        check_retired(2, 1'b0);
        rd_mem(6'd15, w);
        chk(w[29], "R8", "untouched descriptor ownership", 32'(w[29]), 1);
        tx_en = 1'b1;
        exp_q.push_back(3);
        drain(60);
        check_retired(3, 1'b1);
        ack(6'd12);

        // R6 host error and recovery
        put_desc(5, 0, 1'b0);
        kick(6'd20);
        repeat (4) @(negedge clk);
        chk(host_err, "R6", "host_err on unowned", 32'(host_err), 1);
        chk(!active && !pkt_valid && !irq, "R6", "halted on error", 32'(active), 0);
        put_desc(5, 0, 1'b1);
        exp_q.push_back(5);
        kick(6'd20);
        chk(!host_err, "R6", "host_err cleared by head write", 32'(host_err), 0);
        drain(100);
        ack(6'd20);

        // random chains
        for (int it = 0; it < 25; it++) begin
            int len, start, pct;
            len = 1 + ($urandom % 4);
            start = $urandom % 15;
            pct = 30 + ($urandom % 71);
            chain.delete();
            for (int i = 0; i < len; i++) chain.push_back(((start + i) % 15) + 1);
            for (int i = 0; i < len; i++)
                put_desc(chain[i], (i == len - 1) ? 0 : chain[i + 1], 1'b1);
            for (int i = 0; i < len; i++) exp_q.push_back(chain[i]);
            kick(6'(chain[0] * 4));
            drain(pct);
            for (int i = 0; i < len; i++) check_retired(chain[i], i == len - 1);
            chk(irq, "R9", "irq after random chain", 32'(irq), 1);
            ack(6'(chain[len - 1] * 4));
            chk(!irq, "R9", "irq after random chain ack", 32'(irq), 0);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule